// File: doc/BRIEF.md
# Flyback Diode Discharge-Time and Zero-Crossing Detector

This block times the secondary-diode conduction interval of a flyback converter in every switching cycle. It works only from the gate command and a stream of ADC codes of the auxiliary-winding sense voltage. Timing starts when the gate turns off.

During the off phase the block captures a corner reference code. The capture point is a fixed fraction (17/20) of the discharge length measured in the previous cycle. The block declares the zero-crossing once the live code falls more than a programmable number of codes below that held reference. If the gate turns on again before any crossing, the measurement ends with a timeout and the off-time length is taken as the result.

The block also issues a strobe at half of the gate on-time, where a downstream estimator samples the current-sense value. That half point is taken from the on-time of the previous cycle, so the strobe can fire in real time. All outputs are registered: each reflects the inputs sampled at the clock edge that updates it.

Top module: `zcd_dischg_detect`

## Requirements
- R1: While `rst_n` is low, every output is zero. The tap position after reset is floor(17 × MAX_DIS / 20), and it is never below 1.
- R2: The discharge count is 1 in the first cycle in which `gate_i` is sampled low after being high. On a crossing, `dis_time_o` holds the off-cycle position of the sample that caused it.
- R3: The reference code is captured at the off-cycle position equal to the tap, which is max(1, floor(17 × L / 20)). L is the discharge length reported by the previous measurement.
- R4: Before any measurement has completed, the reference is captured at the reset tap given in R1.
- R5: A crossing fires only while the gate is low and only after the reference has been captured in an earlier cycle of the same off phase. The condition is `vs_code_i + DROP_CODE < ref_code_o`; a drop of exactly DROP_CODE does not fire.
- R6: `zcd_o` and `dis_done_o` are single-cycle pulses. A crossing raises both of them together.
- R7: The gate is sampled high while a measurement is open and no crossing has occurred. In that case `dis_time_o` becomes the off-time length in cycles, and `timeout_o` and `dis_done_o` pulse. That length also sets the next tap.
- R8: `cs_strobe_o` pulses once in an on phase, after the on-cycle at position floor(P / 2), where P is the previous on-time in cycles. When floor(P / 2) is 0, there is no strobe.
- R9: The discharge and on-time counters saturate at 2^CNT_W − 1. A timeout after a longer off phase reports that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_i | input | 1 | Power switch gate command, 1 = on |
| vs_code_i | input | ADC_W | ADC code of the auxiliary sense voltage |
| dis_time_o | output | CNT_W | Last measured discharge time in clocks |
| dis_done_o | output | 1 | Pulse: a measurement completed |
| zcd_o | output | 1 | Pulse: zero-crossing detected |
| timeout_o | output | 1 | Pulse: measurement ended by gate turn-on |
| cs_strobe_o | output | 1 | Pulse: midpoint of the on-time |
| ref_code_o | output | ADC_W | Held corner reference code |

## Verification
During each off phase the sense code falls slowly by one code per cycle. The captured reference value therefore shows the exact cycle of capture, which separates the reset tap from later adaptive taps. One pair of cycles steps the sense code to exactly DROP_CODE and then to DROP_CODE + 1 below the reference, which tells a strict comparison from a non-strict one. Other off phases are too short to reach the tap, or far longer than the counter range. These tell a timeout from a crossing and show saturation. On-times of 1, 6, 8, 10 and 12 cycles exercise the midpoint strobe, including the case with no strobe.

// File: rtl/zcd_pkg.sv
package zcd_pkg;

   // floor(num * len / den), never below 1
   function automatic int frac_tap(input int len, input int num, input int den);
      int t;
      t = (num * len) / den;
      return (t < 1) ? 1 : t;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/zcd_tap_calc.sv
module zcd_tap_calc #(
   parameter int CNT_W    = 10,
   parameter int FRAC_NUM = 17,
   parameter int FRAC_DEN = 20
) (
   input  logic [CNT_W-1:0] len_i,
   output logic [CNT_W-1:0] tap_o
);
   localparam int PW = CNT_W + $clog2(FRAC_NUM + 1);
   localparam int SH = $clog2(FRAC_DEN);

   if (FRAC_NUM < 1 || FRAC_NUM > FRAC_DEN) begin : g_bad_frac
      $error("zcd_tap_calc: fraction must lie in (0,1]");
   end

   logic [PW-1:0]    prod;
   logic [PW-1:0]    quot;
   logic [CNT_W-1:0] raw;

   assign prod = PW'(len_i) * PW'(FRAC_NUM);

   if (zcd_pkg::is_pow2(FRAC_DEN)) begin : g_shift
      assign quot = prod >> SH;
   end else begin : g_divide
      assign quot = prod / PW'(FRAC_DEN);
   end

   assign raw   = quot[CNT_W-1:0];
   assign tap_o = (raw == '0) ? CNT_W'(1) : raw;
endmodule

// File: rtl/zcd_on_tracker.sv
module zcd_on_tracker #(
   parameter int CNT_W = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_i,
   output logic fall_o,
   output logic strobe_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             gate_q;
   logic [CNT_W-1:0] on_cnt_q;
   logic [CNT_W-1:0] prev_on_q;
   logic [CNT_W-1:0] pos;
   logic [CNT_W-1:0] half;
   logic             rise;

   assign rise   = gate_i & ~gate_q;
   assign fall_o = ~gate_i & gate_q;
   assign half   = prev_on_q >> 1;
   assign pos    = rise ? CNT_W'(1)
                 : ((on_cnt_q == CNT_MAX) ? on_cnt_q : on_cnt_q + CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q    <= 1'b0;
         on_cnt_q  <= '0;
         prev_on_q <= '0;
         strobe_o  <= 1'b0;
      end else begin
         gate_q   <= gate_i;
         strobe_o <= gate_i && (half != '0) && (pos == half);
         if (gate_i) on_cnt_q <= pos;
         if (fall_o) prev_on_q <= on_cnt_q;
      end
   end
endmodule

// File: rtl/zcd_dis_timer.sv
module zcd_dis_timer #(
   parameter int               ADC_W     = 10,
   parameter int               CNT_W     = 10,
   parameter int               DROP_CODE = 41,
   parameter logic [CNT_W-1:0] TAP_RST   = 340
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_i,
   input  logic             fall_i,
   input  logic [ADC_W-1:0] vs_i,
   input  logic [CNT_W-1:0] scaled_i,
   output logic [CNT_W-1:0] len_o,
   output logic [CNT_W-1:0] dis_time_o,
   output logic             done_o,
   output logic             zcd_o,
   output logic             tmo_o,
   output logic [ADC_W-1:0] ref_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [ADC_W:0]   DROP_V  = (ADC_W+1)'(DROP_CODE);

   if (DROP_CODE < 0 || DROP_CODE >= (1 << ADC_W)) begin : g_bad_drop
      $error("zcd_dis_timer: DROP_CODE out of ADC range");
   end

   logic             meas_q;
   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] tap_q;
   logic [CNT_W-1:0] pos;
   logic             tmo_now;
   logic             zc_now;

   assign pos     = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
   assign tmo_now = meas_q & gate_i;
   assign zc_now  = meas_q & ~gate_i & armed_q &
                    (({1'b0, vs_i} + DROP_V) < {1'b0, ref_o});
   assign len_o   = tmo_now ? cnt_q : pos;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meas_q     <= 1'b0;
         armed_q    <= 1'b0;
         cnt_q      <= '0;
         tap_q      <= TAP_RST;
         dis_time_o <= '0;
         done_o     <= 1'b0;
         zcd_o      <= 1'b0;
         tmo_o      <= 1'b0;
         ref_o      <= '0;
      end else begin
         done_o <= 1'b0;
         zcd_o  <= 1'b0;
         tmo_o  <= 1'b0;
         if (fall_i) begin
            meas_q <= 1'b1;
            cnt_q  <= CNT_W'(1);
            if (tap_q == CNT_W'(1)) begin
               ref_o   <= vs_i;
               armed_q <= 1'b1;
            end else begin
               armed_q <= 1'b0;
            end
         end else if (tmo_now) begin
            meas_q     <= 1'b0;
            dis_time_o <= cnt_q;
            tap_q      <= scaled_i;
            tmo_o      <= 1'b1;
            done_o     <= 1'b1;
         end else if (meas_q) begin
            cnt_q <= pos;
            if (zc_now) begin
               meas_q     <= 1'b0;
               dis_time_o <= pos;
               tap_q      <= scaled_i;
               zcd_o      <= 1'b1;
               done_o     <= 1'b1;
            end else if (!armed_q && pos == tap_q) begin
               ref_o   <= vs_i;
               armed_q <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/zcd_dischg_detect.sv
module zcd_dischg_detect #(
   parameter int ADC_W     = 10,
   parameter int CNT_W     = 10,
   parameter int DROP_CODE = 41,
   parameter int MAX_DIS   = 400,
   parameter int FRAC_NUM  = 17,
   parameter int FRAC_DEN  = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_i,
   input  logic [ADC_W-1:0] vs_code_i,
   output logic [CNT_W-1:0] dis_time_o,
   output logic             dis_done_o,
   output logic             zcd_o,
   output logic             timeout_o,
   output logic             cs_strobe_o,
   output logic [ADC_W-1:0] ref_code_o
);
   localparam int TAP_RST = zcd_pkg::frac_tap(MAX_DIS, FRAC_NUM, FRAC_DEN);

   if (MAX_DIS < 1 || MAX_DIS >= (1 << CNT_W)) begin : g_bad_max
      $error("zcd_dischg_detect: MAX_DIS must fit the counter");
   end

   logic             fall;
   logic [CNT_W-1:0] len;
   logic [CNT_W-1:0] scaled;

   zcd_on_tracker #(.CNT_W(CNT_W)) u_on (
      .clk(clk), .rst_n(rst_n), .gate_i(gate_i),
      .fall_o(fall), .strobe_o(cs_strobe_o)
   );

   zcd_tap_calc #(.CNT_W(CNT_W), .FRAC_NUM(FRAC_NUM), .FRAC_DEN(FRAC_DEN)) u_tap (
      .len_i(len), .tap_o(scaled)
   );

   zcd_dis_timer #(
      .ADC_W(ADC_W), .CNT_W(CNT_W), .DROP_CODE(DROP_CODE),
      .TAP_RST(CNT_W'(TAP_RST))
   ) u_dis (
      .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .fall_i(fall),
      .vs_i(vs_code_i), .scaled_i(scaled), .len_o(len),
      .dis_time_o(dis_time_o), .done_o(dis_done_o), .zcd_o(zcd_o),
      .tmo_o(timeout_o), .ref_o(ref_code_o)
   );
endmodule

// File: rtl/zcd_dischg_detect_chk.sv
module zcd_dischg_detect_chk #(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             gate_i,
   input logic             zcd_i,
   input logic             tmo_i,
   input logic             done_i,
   input logic             strobe_i,
   input logic [CNT_W-1:0] dis_time_i
);
   a_r6_zcd_single: assert property (@(posedge clk) disable iff (!rst_n)
      zcd_i |=> !zcd_i);
   a_r6_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |-> ($countones({zcd_i, tmo_i}) == 1));
   a_r5_zcd_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
      zcd_i |-> !$past(gate_i));
   a_r7_tmo_on_gate: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_i |-> $past(gate_i));
   a_r8_strobe_in_on: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i |-> $past(gate_i));
   a_r2_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |-> (dis_time_i != '0));
endmodule

bind zcd_dischg_detect zcd_dischg_detect_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .zcd_i(zcd_o),
   .tmo_i(timeout_o), .done_i(dis_done_o), .strobe_i(cs_strobe_o),
   .dis_time_i(dis_time_o)
);

// File: tb/zcd_dischg_detect_test.sv
module zcd_dischg_detect_test;
   localparam int CLK_PERIOD = 10;
   localparam int ADC_W = 10;
   localparam int CNT_W = 8;
   localparam int DROP  = 41;
   localparam int MAXD  = 40;
   localparam int CMAX  = 255;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             gate = 1'b0;
   logic [ADC_W-1:0] vs = '0;
   logic [CNT_W-1:0] dis_time;
   logic             done, zcd, tmo, strobe;
   logic [ADC_W-1:0] refc;

   int checks = 0;
   int errors = 0;
   int strobes = 0;
   int rec_dis[$];
   int rec_tmo[$];
   int rec_ref[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   zcd_dischg_detect #(.ADC_W(ADC_W), .CNT_W(CNT_W), .DROP_CODE(DROP),
                       .MAX_DIS(MAXD)) uut (
      .clk(clk), .rst_n(rst_n), .gate_i(gate), .vs_code_i(vs),
      .dis_time_o(dis_time), .dis_done_o(done), .zcd_o(zcd),
      .timeout_o(tmo), .cs_strobe_o(strobe), .ref_code_o(refc)
   );

   // behavioural reference model
   int m_gq, m_on, m_pon, m_meas, m_cnt, m_arm, m_ref, m_tap;
   int m_dis, m_zcd, m_tmo, m_done, m_str;

   function automatic int tapof(input int len);
      int t;
      t = (17 * len) / 20;
      return (t < 1) ? 1 : t;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      int g, v, rise, fall, p, n;
      g = int'(gate); v = int'(vs);
      if (!rst_n) begin
         m_gq = 0; m_on = 0; m_pon = 0; m_meas = 0; m_cnt = 0; m_arm = 0;
         m_ref = 0; m_tap = tapof(MAXD); m_dis = 0; m_zcd = 0; m_tmo = 0;
         m_done = 0; m_str = 0;
      end else begin
         rise = (g == 1 && m_gq == 0) ? 1 : 0;
         fall = (g == 0 && m_gq == 1) ? 1 : 0;
         m_zcd = 0; m_tmo = 0; m_done = 0;
         if (fall == 1) begin
            m_meas = 1; m_cnt = 1; m_arm = 0;
            if (m_tap == 1) begin m_ref = v; m_arm = 1; end
         end else if (m_meas == 1 && g == 1) begin
            m_meas = 0; m_dis = m_cnt; m_tap = tapof(m_cnt);
            m_tmo = 1; m_done = 1;
         end else if (m_meas == 1) begin
            n = (m_cnt + 1 > CMAX) ? CMAX : m_cnt + 1;
            m_cnt = n;
            if (m_arm == 1 && v + DROP < m_ref) begin
               m_meas = 0; m_dis = n; m_tap = tapof(n); m_zcd = 1; m_done = 1;
            end else if (m_arm == 0 && n == m_tap) begin
               m_ref = v; m_arm = 1;
            end
         end
         p = (rise == 1) ? 1 : ((m_on + 1 > CMAX) ? CMAX : m_on + 1);
         m_str = (g == 1 && (m_pon / 2) != 0 && p == m_pon / 2) ? 1 : 0;
         if (fall == 1) m_pon = m_on;
         if (g == 1) m_on = p;
         m_gq = g;
      end
      #2;
      checks++;
      if (int'(dis_time) != m_dis) begin errors++;
         $display("FAIL R2 dis_time: actual %0d expected %0d", dis_time, m_dis); end
      if (int'(zcd) != m_zcd) begin errors++;
         $display("FAIL R5 zcd: actual %0d expected %0d", zcd, m_zcd); end
      if (int'(done) != m_done) begin errors++;
         $display("FAIL R6 done: actual %0d expected %0d", done, m_done); end
      if (int'(tmo) != m_tmo) begin errors++;
         $display("FAIL R7 timeout: actual %0d expected %0d", tmo, m_tmo); end
      if (int'(strobe) != m_str) begin errors++;
         $display("FAIL R8 strobe: actual %0d expected %0d", strobe, m_str); end
      if (int'(refc) != m_ref) begin errors++;
         $display("FAIL R3 ref: actual %0d expected %0d", refc, m_ref); end
      if (strobe) strobes++;
      if (done) begin
         rec_dis.push_back(int'(dis_time));
         rec_tmo.push_back(int'(tmo));
         rec_ref.push_back(int'(refc));
      end
   end

   // one switching cycle; sense code ramps down by one per off cycle,
   // then steps to lo from off position x (x == 0: flat at pl)
   task automatic cycle_run(input int on_len, input int off_len,
                            input int pl, input int lo, input int x);
      for (int i = 0; i < on_len; i++) begin
         @(negedge clk); gate = 1'b1; vs = '0;
      end
      for (int k = 1; k <= off_len; k++) begin
         @(negedge clk); gate = 1'b0;
         if (x == 0) vs = ADC_W'(pl);
         else if (k < x) vs = ADC_W'(pl - k);
         else vs = ADC_W'(lo);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 dis_time reset", int'(dis_time), 0);
      chk("R1 ref reset", int'(refc), 0);
      chk("R1 pulses reset", int'({done, zcd, tmo, strobe}), 0);
      rst_n = 1'b1;
      cycle_run(10, 60, 500, 400, 45);   // R4: tap 34
      chk("R4 ref at reset tap", int'(refc), 466);
      cycle_run(12, 60, 520, 430, 50);   // R3: tap 38
      cycle_run(6, 60, 500, 417, 44);    // R5: exactly DROP below, tap 42
      cycle_run(6, 60, 500, 407, 55);    // R5: DROP+1 below, tap 51
      cycle_run(1, 300, 500, 0, 0);      // R9: saturation, tap 46
      cycle_run(8, 20, 500, 0, 0);       // R7: short off, tap 216
      cycle_run(8, 40, 600, 500, 25);    // R3: tap 17
      @(negedge clk); gate = 1'b1;
      repeat (3) @(negedge clk);
      gate = 1'b0;
      repeat (3) @(negedge clk);

      chk("R2 done count", rec_dis.size(), 7);
      if (rec_dis.size() == 7) begin
         chk("R2 first length", rec_dis[0], 45);
         chk("R3 second length", rec_dis[1], 50);
         chk("R3 second ref", rec_ref[1], 482);
         chk("R5 exact drop ignored", rec_tmo[2], 1);
         chk("R7 off length", rec_dis[2], 60);
         chk("R5 strict drop crosses", rec_dis[3], 55);
         chk("R5 crossing ref", rec_ref[3], 449);
         chk("R9 saturated length", rec_dis[4], CMAX);
         chk("R9 timeout flag", rec_tmo[4], 1);
         chk("R7 short off timeout", rec_dis[5], 20);
         chk("R3 tap from timeout", rec_ref[6], 583);
         chk("R2 last length", rec_dis[6], 25);
      end
      chk("R8 strobe count", strobes, 4);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule